// File: doc/BRIEF.md
# Packed Lane Adder with Greater-or-Equal Flags

This unit treats a 32-bit word as four independent byte lanes or two independent halfword lanes. In a single cycle it adds or subtracts the matching lanes of two operands, in either unsigned or two's-complement form. Each lane's result wraps to the lane width. Each lane also produces a greater-or-equal flag, and the unit can capture these flags in a 4-bit flag register.

The meaning of the flag depends on the operation. For an unsigned add it is the carry out of the lane. For an unsigned subtract it means no borrow occurred. For any signed operation it means the exact, unwrapped result is non-negative. When the lanes are halfwords, each lane's flag fills two adjacent flag bits.

A second operation, select, uses the stored flags as a byte mask. For each result byte it takes the byte from the first operand when that byte's flag is set, and from the second operand otherwise. Software can also load the flag register directly through a separate write port.

Top module: `simd_ge_unit`

## Requirements
- R1: With `half_mode`=0 and `op_sel`=0, result byte k (bits 8k+7..8k) equals the byte-k sum or difference of the operands modulo 256.
- R2: With `half_mode`=1 and `op_sel`=0, result halfword k (bits 16k+15..16k) equals the halfword-k sum or difference modulo 65536. No carry crosses between the two halfwords.
- R3: For an unsigned add (`do_sub`=0, `is_signed`=0), a lane's flag is 1 exactly when the true sum is at least 2^8 (byte lane) or 2^16 (halfword lane).
- R4: For an unsigned subtract (`do_sub`=1, `is_signed`=0), a lane's flag is 1 exactly when the first operand lane is greater than or equal to the second, so that no borrow occurs.
- R5: For a signed add or subtract, a lane's flag is 1 exactly when the exact result is at least zero. This holds even when the wrapped result has the opposite sign.
- R6: Flag bit k belongs to byte lane k (bit 3 is the top byte). In halfword mode, bits 3 and 2 both take the upper lane's flag, and bits 1 and 0 both take the lower lane's flag.
- R7: The flag register `ge_flags` loads the new lane flags on the clock edge when `arith_en`=1 and `op_sel`=0. With no write of either kind, it holds its value.
- R8: With `op_sel`=1, result byte k equals `op_a` byte k when stored flag bit k is 1, and `op_b` byte k otherwise.
- R9: A select operation (`op_sel`=1) never changes the flags, even when `arith_en`=1.
- R10: When `flag_wr_en`=1, the flag register loads `flag_wr_data` on the clock edge. When an arithmetic flag write happens in the same cycle, the arithmetic flags win.
- R11: A synchronous active-high `rst` clears `ge_flags` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| half_mode | input | 1 | 0 = four byte lanes, 1 = two halfword lanes |
| do_sub | input | 1 | 0 = add, 1 = subtract (op_a minus op_b) |
| is_signed | input | 1 | 1 = two's-complement lanes |
| op_sel | input | 1 | 1 = byte select driven by the stored flags |
| arith_en | input | 1 | Write enable for the lane flags of an add/subtract |
| flag_wr_en | input | 1 | Direct flag load enable |
| flag_wr_data | input | 4 | Direct flag load value |
| result | output | 32 | Lane result or selected word (combinational) |
| ge_flags | output | 4 | Stored greater-or-equal flags |

## Verification
A flag register that holds a wrong value shows up on `ge_flags` one clock edge after the faulty write. It then corrupts the very next select, whose result bytes come from the wrong operand in that same cycle. A carry that leaks across lanes, or a flag taken from the wrong guard bit, shows up on `result` or on the flags as soon as the next edge. The tests therefore use signed overflow, exact-zero differences and all-ones carries. Each test follows an arithmetic write with a select, so that a wrong stored state is exposed through the combinational result path.

// File: rtl/simd_ge_pkg.sv
package simd_ge_pkg;

    typedef enum logic {
        LANE_BYTE = 1'b0,
        LANE_HALF = 1'b1
    } lane_size_e;

    typedef struct packed {
        lane_size_e size;
        logic       sub;
        logic       sgn;
    } arith_ctl_t;

    // The guard bit is the top bit of a one-bit-wider exact result.
    // Unsigned add: guard is the carry. Otherwise, guard set means negative.
    function automatic logic lane_flag(input logic sub, input logic sgn, input logic guard);
        return (!sub && !sgn) ? guard : ~guard;
    endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_ge_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sgn,
    output logic [W-1:0] sum,
    output logic         ge
);
    logic [W:0] ax, bx, ex;

    always_comb begin
        ax  = {sgn & a[W-1], a};
        bx  = {sgn & b[W-1], b};
        ex  = sub ? (ax - bx) : (ax + bx);
        sum = ex[W-1:0];
        ge  = lane_flag(sub, sgn, ex[W]);
    end
endmodule

// File: rtl/simd_arith.sv
module simd_arith
    import simd_ge_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4
) (
    input  logic [BYTE_W*NUM_BYTES-1:0] a,
    input  logic [BYTE_W*NUM_BYTES-1:0] b,
    input  arith_ctl_t                  ctl,
    output logic [BYTE_W*NUM_BYTES-1:0] sum,
    output logic [NUM_BYTES-1:0]        ge
);
    localparam int WORD_W     = BYTE_W * NUM_BYTES;
    localparam int HALF_W     = 2 * BYTE_W;
    localparam int NUM_HALVES = NUM_BYTES / 2;

    logic [WORD_W-1:0]     sum_b, sum_h;
    logic [NUM_BYTES-1:0]  ge_b, ge_h;

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        simd_lane #(.W(BYTE_W)) u_lane (
            .a   (a[i*BYTE_W +: BYTE_W]),
            .b   (b[i*BYTE_W +: BYTE_W]),
            .sub (ctl.sub),
            .sgn (ctl.sgn),
            .sum (sum_b[i*BYTE_W +: BYTE_W]),
            .ge  (ge_b[i])
        );
    end

    for (genvar k = 0; k < NUM_HALVES; k++) begin : g_half
        logic ge_one;
        simd_lane #(.W(HALF_W)) u_lane (
            .a   (a[k*HALF_W +: HALF_W]),
            .b   (b[k*HALF_W +: HALF_W]),
            .sub (ctl.sub),
            .sgn (ctl.sgn),
            .sum (sum_h[k*HALF_W +: HALF_W]),
            .ge  (ge_one)
        );
        assign ge_h[2*k +: 2] = {2{ge_one}};
    end

    always_comb begin
        if (ctl.size == LANE_HALF) begin
            sum = sum_h;
            ge  = ge_h;
        end else begin
            sum = sum_b;
            ge  = ge_b;
        end
    end
endmodule

// File: rtl/simd_ge_reg.sv
module simd_ge_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arith_wr,
    input  logic [N-1:0] arith_ge,
    input  logic         dir_wr,
    input  logic [N-1:0] dir_data,
    output logic [N-1:0] ge_q
);
    always_ff @(posedge clk) begin
        if (rst)           ge_q <= '0;
        else if (arith_wr) ge_q <= arith_ge;
        else if (dir_wr)   ge_q <= dir_data;
    end

    // R7: no write of either kind leaves the flags unchanged
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!arith_wr && !dir_wr) |=> $stable(ge_q));

    // R10: a lone direct write lands on the next edge
    a_r10_direct_load: assert property (@(posedge clk) disable iff (rst)
        (dir_wr && !arith_wr) |=> (ge_q == $past(dir_data)));
endmodule

// File: rtl/simd_byte_sel.sv
module simd_byte_sel #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4
) (
    input  logic [BYTE_W*NUM_BYTES-1:0] a,
    input  logic [BYTE_W*NUM_BYTES-1:0] b,
    input  logic [NUM_BYTES-1:0]        mask,
    output logic [BYTE_W*NUM_BYTES-1:0] y
);
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_mux
        assign y[i*BYTE_W +: BYTE_W] = mask[i] ? a[i*BYTE_W +: BYTE_W]
                                               : b[i*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/simd_ge_unit.sv
module simd_ge_unit
    import simd_ge_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [BYTE_W*NUM_BYTES-1:0] op_a,
    input  logic [BYTE_W*NUM_BYTES-1:0] op_b,
    input  logic                        half_mode,
    input  logic                        do_sub,
    input  logic                        is_signed,
    input  logic                        op_sel,
    input  logic                        arith_en,
    input  logic                        flag_wr_en,
    input  logic [NUM_BYTES-1:0]        flag_wr_data,
    output logic [BYTE_W*NUM_BYTES-1:0] result,
    output logic [NUM_BYTES-1:0]        ge_flags
);
    localparam int WORD_W = BYTE_W * NUM_BYTES;

    arith_ctl_t           ctl;
    logic [WORD_W-1:0]    arith_sum, sel_word;
    logic [NUM_BYTES-1:0] lane_ge;
    logic                 arith_wr;

    assign ctl.size = half_mode ? LANE_HALF : LANE_BYTE;
    assign ctl.sub  = do_sub;
    assign ctl.sgn  = is_signed;
    assign arith_wr = arith_en && !op_sel;

    simd_arith #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_arith (
        .a   (op_a),
        .b   (op_b),
        .ctl (ctl),
        .sum (arith_sum),
        .ge  (lane_ge)
    );

    simd_ge_reg #(.N(NUM_BYTES)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .arith_wr (arith_wr),
        .arith_ge (lane_ge),
        .dir_wr   (flag_wr_en),
        .dir_data (flag_wr_data),
        .ge_q     (ge_flags)
    );

    simd_byte_sel #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_sel (
        .a    (op_a),
        .b    (op_b),
        .mask (ge_flags),
        .y    (sel_word)
    );

    assign result = op_sel ? sel_word : arith_sum;

    // R6: a halfword write leaves each flag pair equal
    a_r6_half_pairs: assert property (@(posedge clk) disable iff (rst)
        (arith_wr && half_mode && !flag_wr_en) |=>
            (ge_flags[3] == ge_flags[2]) && (ge_flags[1] == ge_flags[0]));

    // R9: a select with no direct write keeps the flags
    a_r9_select_keeps: assert property (@(posedge clk) disable iff (rst)
        (op_sel && !flag_wr_en) |=> $stable(ge_flags));
endmodule

// File: tb/simd_ge_unit_test.sv
module simd_ge_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0, op_b = '0;
    logic        half_mode = 1'b0, do_sub = 1'b0, is_signed = 1'b0;
    logic        op_sel = 1'b0, arith_en = 1'b0, flag_wr_en = 1'b0;
    logic [3:0]  flag_wr_data = '0;
    logic [31:0] result;
    logic [3:0]  ge_flags;

    int n_checks = 0;
    int n_fails  = 0;
    logic [3:0] exp_ge = 4'h0;

    always #5 clk = ~clk;

    simd_ge_unit uut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .half_mode(half_mode), .do_sub(do_sub), .is_signed(is_signed),
        .op_sel(op_sel), .arith_en(arith_en), .flag_wr_en(flag_wr_en),
        .flag_wr_data(flag_wr_data), .result(result), .ge_flags(ge_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Independent lane model using integer arithmetic; returns {flags, result}
    function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic half, input logic sub, input logic sgn);
        logic [31:0] res = '0;
        logic [3:0]  fl = '0;
        int w = half ? 16 : 8;
        int n = half ? 2 : 4;
        for (int i = 0; i < n; i++) begin
            longint av = (a >> (w*i)) & ((64'd1 << w) - 1);
            longint bv = (b >> (w*i)) & ((64'd1 << w) - 1);
            longint ex;
            logic f;
            if (sgn && av >= (64'd1 << (w-1))) av = av - (64'd1 << w);
            if (sgn && bv >= (64'd1 << (w-1))) bv = bv - (64'd1 << w);
            ex = sub ? av - bv : av + bv;
            res = res | (32'(ex & ((64'd1 << w) - 1)) << (w*i));
            f = (!sgn && !sub) ? (ex >= (64'd1 << w)) : (ex >= 0);
            if (half) fl[2*i +: 2] = {f, f};
            else      fl[i] = f;
        end
        return {fl, res};
    endfunction

    task automatic run_arith(input string req, input logic [31:0] a, input logic [31:0] b,
                             input logic half, input logic sub, input logic sgn,
                             input logic en);
        logic [35:0] m;
        @(negedge clk);
        op_a = a; op_b = b; half_mode = half; do_sub = sub; is_signed = sgn;
        op_sel = 1'b0; arith_en = en; flag_wr_en = 1'b0;
        m = model(a, b, half, sub, sgn);
        #1 check({req, " result"}, result, m[31:0]);
        if (en) exp_ge = m[35:32];
        @(posedge clk); #1;
        arith_en = 1'b0;
        check({req, " flags"}, {28'h0, ge_flags}, {28'h0, exp_ge});
    endtask

    task automatic run_select(input string req, input logic [31:0] a, input logic [31:0] b,
                              input logic en);
        logic [31:0] e;
        @(negedge clk);
        op_a = a; op_b = b; op_sel = 1'b1; arith_en = en; flag_wr_en = 1'b0;
        for (int i = 0; i < 4; i++) e[8*i +: 8] = exp_ge[i] ? a[8*i +: 8] : b[8*i +: 8];
        #1 check({req, " select"}, result, e);
        @(posedge clk); #1;
        op_sel = 1'b0; arith_en = 1'b0;
        check("R9 flags after select", {28'h0, ge_flags}, {28'h0, exp_ge});
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        check("R11 reset flags", {28'h0, ge_flags}, 32'h0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_byte_unsigned();
        run_arith("R1 R3 byte uadd", 32'h80FF0110, 32'h80010F01, 1'b0, 1'b0, 1'b0, 1'b1);
        run_arith("R1 R3 byte uadd max", 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 1'b0, 1'b1);
        run_arith("R4 byte usub", 32'h05100000, 32'h05200001, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_byte_signed();
        run_arith("R5 byte sadd ovf", 32'h7F80FF01, 32'h0180FF01, 1'b0, 1'b0, 1'b1, 1'b1);
        run_arith("R5 byte ssub", 32'h807F0000, 32'h01FF0001, 1'b0, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_half();
        run_arith("R2 R3 R6 half uadd", 32'hFFFF8000, 32'h00018001, 1'b1, 1'b0, 1'b0, 1'b1);
        run_arith("R2 R4 R6 half usub", 32'h00001234, 32'h00011234, 1'b1, 1'b1, 1'b0, 1'b1);
        run_arith("R2 R5 R6 half ssub", 32'h80007FFF, 32'h0001FFFF, 1'b1, 1'b1, 1'b1, 1'b1);
        run_arith("R2 R5 half sadd", 32'h7FFF00FF, 32'h00010001, 1'b1, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_hold();
        run_arith("R7 no write holds", 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_select();
        run_select("R8 select after arith", 32'h11223344, 32'hAABBCCDD, 1'b1);
        run_arith("R8 set 0101", 32'h00FF00FF, 32'h01000100, 1'b0, 1'b1, 1'b0, 1'b1);
        run_select("R8 R9 select mask 0101", 32'h11223344, 32'hAABBCCDD, 1'b1);
    endtask

    task automatic t_direct();
        @(negedge clk);
        flag_wr_en = 1'b1; flag_wr_data = 4'b1010; arith_en = 1'b0; op_sel = 1'b0;
        @(posedge clk); #1;
        flag_wr_en = 1'b0; exp_ge = 4'b1010;
        check("R10 direct load", {28'h0, ge_flags}, 32'hA);
        run_select("R8 R10 select after load", 32'h11223344, 32'hAABBCCDD, 1'b0);
        @(negedge clk);
        op_a = 32'hFFFFFFFF; op_b = 32'h00000001; half_mode = 1'b0; do_sub = 1'b0;
        is_signed = 1'b0; arith_en = 1'b1; flag_wr_en = 1'b1; flag_wr_data = 4'b0000;
        @(posedge clk); #1;
        arith_en = 1'b0; flag_wr_en = 1'b0; exp_ge = 4'b0001;
        check("R10 arith wins", {28'h0, ge_flags}, 32'h1);
        @(negedge clk);
        op_sel = 1'b1; flag_wr_en = 1'b1; flag_wr_data = 4'b0110;
        @(posedge clk); #1;
        op_sel = 1'b0; flag_wr_en = 1'b0; exp_ge = 4'b0110;
        check("R10 load during select", {28'h0, ge_flags}, 32'h6);
    endtask

    initial begin
        #200000;
        n_checks++; n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_byte_unsigned();
        t_byte_signed();
        t_half();
        t_hold();
        t_select();
        t_direct();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule